// File: doc/BRIEF.md
# Ping Onset Detector

This block watches one hydrophone channel's stream of 12-bit samples and decides when a real ping has begun. Each sample is compared against a running DC estimate that is supplied from outside. The detector first requires an unbroken run of quiet samples near the DC level. Only after that run does it arm. Once armed, it waits for a sample whose distance from the DC level is larger than an onset threshold.

Echoes of the ping arrive while the channel is still ringing, so no quiet run comes before them. Because of this the detector never arms for an echo. Isolated noise spikes are rejected in the same way. After a detection the flag stays latched until downstream logic has taken the channel's data and pulses clear.

Top module: `ping_onset_detector`

## Requirements
- R1: After reset, ping_o is low, the detector is in the counting state and the quiet count is zero.
- R2: The deviation of a sample is |sample_i - dc_level_i|. A sample is quiet when its deviation is less than or equal to quiet_thresh_i. A sample exactly at the threshold is quiet, and one code above it is not.
- R3: While counting, each valid quiet sample raises the quiet count by one. Each valid non-quiet sample sets the count to zero. The detector arms on the valid quiet sample that brings the count above quiet_len_i, so it needs quiet_len_i+1 consecutive quiet samples.
- R4: Cycles with sample_valid_i low change neither the quiet count nor the state.
- R5: A loud sample that arrives before the detector has armed does not set ping_o. It also zeroes the quiet count.
- R6: While armed, a valid sample whose deviation is greater than onset_thresh_i sets ping_o high from the next cycle on. This holds for excursions above and below the DC level.
- R7: While armed, a valid sample that is neither quiet nor above onset_thresh_i disarms the detector and sets the quiet count to zero.
- R8: Once set, ping_o stays high and samples are ignored until clear_i is asserted.
- R9: clear_i, in any state, returns the detector to counting with a zero count from the next cycle. It takes priority over a sample presented in the same cycle.
- R10: The quiet count saturates at all-ones and never wraps. With quiet_len_i at all-ones the detector never arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Marks sample_i as a new sample |
| sample_i | input | DW (12) | Unsigned ADC sample |
| dc_level_i | input | DW (12) | Current DC estimate of the channel |
| quiet_thresh_i | input | DW (12) | Largest deviation that still counts as quiet |
| quiet_len_i | input | CNT_W (16) | Quiet run length that must be exceeded before arming |
| onset_thresh_i | input | DW (12) | Deviation that must be exceeded to accept an onset |
| clear_i | input | 1 | Drops the detection and restarts counting |
| ping_o | output | 1 | Latched ping-detected flag |

## Verification
Two cases are hard to reach from the ports: saturation of the quiet count, and the boundary of the arming condition. A stray loud sample, or a lapse in the valid strobe, easily shifts the count by one. The stimulus places loud samples exactly one sample before the arming point and exactly at it, with invalid cycles mixed into the quiet run. The bench is built with a narrow count width so that a run longer than the count's range, with quiet_len_i at all-ones, fits in a short test.

// File: rtl/pod_pkg.sv
package pod_pkg;
  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_ARMED = 2'd1,
    ST_HIT   = 2'd2
  } pod_state_e;
endpackage

// File: rtl/pod_deviation.sv
module pod_deviation #(
  parameter int DW = 12
) (
  input  logic [DW-1:0] sample_i,
  input  logic [DW-1:0] dc_i,
  input  logic [DW-1:0] quiet_thresh_i,
  input  logic [DW-1:0] onset_thresh_i,
  output logic          quiet_o,
  output logic          loud_o
);
  logic [DW-1:0] dev;

  always_comb begin
    if (sample_i >= dc_i) dev = sample_i - dc_i;
    else                  dev = dc_i - sample_i;
  end

  assign quiet_o = (dev <= quiet_thresh_i);
  assign loud_o  = (dev >  onset_thresh_i);
endmodule

// File: rtl/pod_quiet_ctr.sv
module pod_quiet_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (zero_i)                     cnt_o <= '0;
    else if (inc_i && (cnt_o != CntMax)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pod_ctrl.sv
module pod_ctrl
  import pod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             clear_i,
  input  logic             quiet_i,
  input  logic             loud_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] quiet_len_i,
  output logic             zero_o,
  output logic             inc_o,
  output pod_state_e       state_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  pod_state_e       state_d;
  logic [CNT_W-1:0] cnt_next;
  logic             arm;

  // value the counter takes after this quiet sample
  assign cnt_next = (cnt_i == CntMax) ? cnt_i : cnt_i + 1'b1;
  assign arm      = cnt_next > quiet_len_i;

  always_comb begin
    state_d = state_o;
    zero_o  = 1'b0;
    inc_o   = 1'b0;
    if (clear_i) begin
      state_d = ST_COUNT;
      zero_o  = 1'b1;
    end else if (valid_i) begin
      unique case (state_o)
        ST_COUNT: begin
          if (quiet_i) begin
            inc_o = 1'b1;
            if (arm) state_d = ST_ARMED;
          end else begin
            zero_o = 1'b1;
          end
        end
        ST_ARMED: begin
          if (loud_i) begin
            state_d = ST_HIT;
          end else if (!quiet_i) begin
            state_d = ST_COUNT;
            zero_o  = 1'b1;
          end
        end
        ST_HIT:  ;
        default: state_d = ST_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_COUNT;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/ping_onset_detector.sv
module ping_onset_detector
  import pod_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_valid_i,
  input  logic [DW-1:0]    sample_i,
  input  logic [DW-1:0]    dc_level_i,
  input  logic [DW-1:0]    quiet_thresh_i,
  input  logic [CNT_W-1:0] quiet_len_i,
  input  logic [DW-1:0]    onset_thresh_i,
  input  logic             clear_i,
  output logic             ping_o
);
  logic             quiet, loud, cnt_zero, cnt_inc;
  logic [CNT_W-1:0] cnt_q;
  pod_state_e       state_q;

  pod_deviation #(.DW(DW)) u_dev (
    .sample_i       (sample_i),
    .dc_i           (dc_level_i),
    .quiet_thresh_i (quiet_thresh_i),
    .onset_thresh_i (onset_thresh_i),
    .quiet_o        (quiet),
    .loud_o         (loud)
  );

  pod_quiet_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .zero_i (cnt_zero),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt_q)
  );

  pod_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (sample_valid_i),
    .clear_i     (clear_i),
    .quiet_i     (quiet),
    .loud_i      (loud),
    .cnt_i       (cnt_q),
    .quiet_len_i (quiet_len_i),
    .zero_o      (cnt_zero),
    .inc_o       (cnt_inc),
    .state_o     (state_q)
  );

  assign ping_o = (state_q == ST_HIT);
endmodule

// File: rtl/pod_chk.sv
module pod_chk
  import pod_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_valid_i,
  input logic             clear_i,
  input logic             ping_o,
  input logic             quiet,
  input logic [CNT_W-1:0] cnt_q,
  input pod_state_e       state_q
);
  // R6
  onset_needs_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ping_o) |-> $past(sample_valid_i && !clear_i));

  // R5
  onset_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ping_o) |-> $past(state_q == ST_ARMED));

  // R8
  ping_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ping_o && !clear_i |=> ping_o);

  // R9
  clear_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ping_o && (cnt_q == '0));

  // R4
  idle_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i && !clear_i |=> $stable(cnt_q) && $stable(state_q));

  // R10
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && sample_valid_i && quiet && !clear_i |=> (cnt_q != '0));
endmodule

bind ping_onset_detector pod_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .clear_i        (clear_i),
  .ping_o         (ping_o),
  .quiet          (quiet),
  .cnt_q          (cnt_q),
  .state_q        (state_q)
);

// File: tb/ping_onset_detector_tb.sv
module ping_onset_detector_tb;
  localparam int DW    = 12;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             vld = 1'b0;
  logic [DW-1:0]    smp = '0;
  logic [DW-1:0]    dc = '0;
  logic [DW-1:0]    qth = '0;
  logic [CNT_W-1:0] qlen = '0;
  logic [DW-1:0]    oth = '0;
  logic             clr = 1'b0;
  logic             ping;

  int vectors = 0;
  int errors  = 0;
  int m_st    = 0;  // 0 counting, 1 armed, 2 detected
  int m_cnt   = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  ping_onset_detector #(.DW(DW), .CNT_W(CNT_W)) u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .sample_valid_i (vld),
    .sample_i       (smp),
    .dc_level_i     (dc),
    .quiet_thresh_i (qth),
    .quiet_len_i    (qlen),
    .onset_thresh_i (oth),
    .clear_i        (clr),
    .ping_o         (ping)
  );

  task automatic compare(input string tag);
    vectors++;
    if (ping !== (m_st == 2)) begin
      errors++;
      $display("FAIL %s: ping_o=%0b expected %0b", tag, ping, (m_st == 2));
    end
  endtask

  task automatic model_step();
    int dev;
    bit q, l;
    dev = int'(smp) - int'(dc);
    if (dev < 0) dev = -dev;
    q = dev <= int'(qth);
    l = dev > int'(oth);
    if (clr) begin
      m_st = 0; m_cnt = 0;
    end else if (vld) begin
      if (m_st == 0) begin
        if (q) begin
          if (m_cnt < CMAX) m_cnt++;
          if (m_cnt > int'(qlen)) m_st = 1;
        end else m_cnt = 0;
      end else if (m_st == 1) begin
        if (l) m_st = 2;
        else if (!q) begin m_st = 0; m_cnt = 0; end
      end
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit v, input int s, input bit c, input string tag);
    vld = v; smp = DW'(s); clr = c;
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet_run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 2000 + ((i % 2) ? 20 : -20), 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: timeout actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    dc = 12'd2000; qth = 12'd20; qlen = 6'd5; oth = 12'd200;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, "R1");

    // R2: deviation 21 is not quiet, 20 is
    quiet_run(4, "R2");
    step(1'b1, 2021, 1'b0, "R2");
    quiet_run(5, "R2");
    step(1'b1, 2500, 1'b0, "R5");   // 5 quiet then loud: not armed yet
    step(1'b0, 0, 1'b0, "R5");

    // R3/R4: 6 quiet samples with invalid gaps, then negative onset
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1980, 1'b0, "R3");
      step(1'b0, 3000, 1'b0, "R4");
    end
    step(1'b1, 1700, 1'b0, "R6");
    step(1'b1, 2000, 1'b0, "R8");
    step(1'b1, 100, 1'b0, "R8");
    step(1'b0, 0, 1'b0, "R8");

    // R9: clear wins over a same-cycle loud sample
    step(1'b1, 4000, 1'b1, "R9");
    quiet_run(6, "R9");
    step(1'b1, 2300, 1'b0, "R6");    // positive onset
    step(1'b0, 0, 1'b1, "R9");

    // R7: medium deviation disarms; exactly onset threshold is not loud
    quiet_run(6, "R7");
    step(1'b1, 2200, 1'b0, "R7");
    step(1'b1, 2900, 1'b0, "R7");
    quiet_run(6, "R7");
    step(1'b1, 1900, 1'b0, "R7");
    step(1'b1, 2900, 1'b0, "R7");

    // extremes of the code range
    dc = 12'd4095;
    quiet_run(0, "R2");
    for (int i = 0; i < 6; i++) step(1'b1, 4090, 1'b0, "R3");
    step(1'b1, 0, 1'b0, "R6");
    step(1'b0, 0, 1'b1, "R9");
    dc = 12'd2000;

    // R10: run past saturation with length all-ones never arms
    qlen = 6'h3f;
    quiet_run(CMAX + 10, "R10");
    step(1'b1, 2600, 1'b0, "R10");
    qlen = 6'd62;
    quiet_run(CMAX + 10, "R10");
    step(1'b1, 2600, 1'b0, "R10");
    step(1'b0, 0, 1'b1, "R9");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule